// File: doc/BRIEF.md
# UART Channel Interrupt Status and Masking

This block collects the interrupt sources of one serial channel into an eight-bit status word and produces an active-low interrupt request. Two of the status bits are level-driven. One follows the receive FIFO fill count against a programmable trigger level. The other follows the transmit FIFO fill count against its own trigger level. A third bit comes from an internal receive watchdog that counts bit-time ticks. Four further bits are sticky event flags: break change, address match, flow-control character and input-pin change. Each of these sets on a one-cycle event pulse and clears on its own clearing action.

An eight-bit mask register selects which status bits may request service. The request output is low whenever a status bit and its mask bit are both 1. The host reads the status through a read-data output. A mode input selects whether that read shows the raw status or the status already ANDed with the mask. The event detectors, the FIFOs and the arbitration between channels sit outside this block. Only their pulses and fill counts arrive here.

Top module: `uart_irq_status`

## Requirements
- R1: The status word has this layout: bit 7 input-pin change, bit 6 watchdog timeout, bit 5 address match, bit 4 flow-control character, bit 3 constant 0, bit 2 break change, bit 1 receive ready, bit 0 transmit ready.
- R2: `irq_n` is 0 exactly when some status bit and the matching mask bit are both 1. The mask is loaded from `mask_wdata` on a clock with `mask_wr` = 1, and its bit 3 is stored as 0.
- R3: With `masked_rd` = 0 the read data equals the status word. With `masked_rd` = 1 the read data equals the status word ANDed with the mask.
- R4: The watchdog bit goes to 1 in the cycle after the 65th `baud_tick` counted since reset or since the last `rx_push`/`rx_read`. After that it holds at 1. A clock with `rx_push` or `rx_read` clears it and restarts the count, and this takes priority over a tick in the same clock.
- R5: The receive-ready bit follows `rx_level` as a pure function of it. The `rx_trig` codes are 00 for level ≥ 1, 01 for level ≥ 8, 10 for level ≥ 12 and 11 for level ≥ 16.
- R6: The transmit-ready bit follows `tx_level` as a pure function of it. The `tx_trig` codes are 00 for level = 0 (all 16 places free), 01 for level < 4, 10 for level < 8 and 11 for level < 16.
- R7: The break-change bit sets on a clock with `brk_evt`. It clears on a clock with `cmd_valid` and `cmd_code` = 5'b00101. A set in the same clock as a clear wins.
- R8: The address bit sets on `addr_evt` and clears on command 5'b11011. The flow-control bit sets on `flow_evt` and clears on `flow_rd`. The input-change bit sets on `cos_evt` and clears on `inport_rd`. In each case a set in the same clock wins.
- R9: A command with any other code leaves all sticky bits unchanged.
- R10: After reset the sticky bits, the watchdog bit and the mask are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One pulse per received bit time |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_read | input | 1 | Host read of receive FIFO |
| rx_level | input | 5 | Receive FIFO fill count, 0..16 |
| tx_level | input | 5 | Transmit FIFO fill count, 0..16 |
| rx_trig | input | 2 | Receive trigger code |
| tx_trig | input | 2 | Transmit trigger code |
| brk_evt | input | 1 | Break start or end detected |
| addr_evt | input | 1 | Address match detected |
| flow_evt | input | 1 | Flow-control character detected |
| cos_evt | input | 1 | Input pin change detected |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| flow_rd | input | 1 | Read of flow-control event register |
| inport_rd | input | 1 | Read of input port register |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| masked_rd | input | 1 | Read mode: 0 raw, 1 masked |
| rd_data | output | 8 | Status read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench steps the watchdog past 64 ticks and checks the 65th tick exactly. A design with an off-by-one count would raise timeout one tick early or late. A design that ignores push/tick priority would keep counting through the event. Every trigger code is driven against fill levels at the thresholds, just below them and at zero. This catches a `>` used where `≥` belongs, and catches the transmit code 00 if it is wrongly treated as "any space". The bench also fires set and clear in the same clock and sends non-matching command codes. A design that lets the clear win would drop the event, and one with loose code decoding would wipe flags it should keep.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int BIT_TXR  = 0;
  localparam int BIT_RXR  = 1;
  localparam int BIT_BRK  = 2;
  localparam int BIT_RSV  = 3;
  localparam int BIT_FLOW = 4;
  localparam int BIT_ADDR = 5;
  localparam int BIT_WDOG = 6;
  localparam int BIT_COS  = 7;

  localparam logic [4:0] CMD_CLR_BRK  = 5'b00101;
  localparam logic [4:0] CMD_CLR_ADDR = 5'b11011;

  // receive side: ready when fill meets or exceeds the selected threshold
  function automatic logic rx_ready_fn(input int unsigned lvl,
                                       input logic [1:0] trig,
                                       input int unsigned depth);
    int unsigned thr;
    case (trig)
      2'b00:   thr = 1;
      2'b01:   thr = depth / 2;
      2'b10:   thr = (depth * 3) / 4;
      default: thr = depth;
    endcase
    return lvl >= thr;
  endfunction

  // transmit side: code 00 wants a fully empty FIFO, others a fill below the threshold
  function automatic logic tx_ready_fn(input int unsigned lvl,
                                       input logic [1:0] trig,
                                       input int unsigned depth);
    case (trig)
      2'b00:   return lvl == 0;
      2'b01:   return lvl < depth / 4;
      2'b10:   return lvl < depth / 2;
      default: return lvl < depth;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] flag_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]); // R7, R8
    AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]); // R7, R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(flag_o[g])); // R9
  end
endmodule

// File: rtl/uart_irq_rx_wdog.sv
module uart_irq_rx_wdog #(
  parameter int WDOG_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic fifo_evt,
  output logic timeout
);
  localparam int LIMIT = WDOG_BITS + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          at_limit;
  logic          fire;

  assign at_limit = (cnt == CW'(LIMIT));
  assign fire     = baud_tick && !fifo_evt && (cnt == CW'(WDOG_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (fifo_evt) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (baud_tick && !at_limit) begin
      cnt <= cnt + CW'(1);
      if (fire) timeout <= 1'b1;
    end
  end

  AST_WDOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_evt |=> !timeout); // R4
  AST_WDOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !fifo_evt) |=> timeout); // R4
  AST_WDOG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeout && !baud_tick) |=> !timeout); // R4
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int FIFO_DEPTH = 16,
  parameter int WDOG_BITS  = 64,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx_push,
  input  logic          rx_read,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [1:0]    rx_trig,
  input  logic [1:0]    tx_trig,
  input  logic          brk_evt,
  input  logic          addr_evt,
  input  logic          flow_evt,
  input  logic          cos_evt,
  input  logic          cmd_valid,
  input  logic [4:0]    cmd_code,
  input  logic          flow_rd,
  input  logic          inport_rd,
  input  logic          mask_wr,
  input  logic [7:0]    mask_wdata,
  input  logic          masked_rd,
  output logic [7:0]    rd_data,
  output logic          irq_n
);
  import uart_irq_pkg::*;

  localparam int NSTICKY = 4; // order: brk, flow, addr, cos

  logic [NSTICKY-1:0] st_set, st_clr, st_q;
  logic               wdog_to;
  logic               rx_rdy, tx_rdy;
  logic               fifo_evt;
  logic [7:0]         isr, mask_q, pending;

  assign fifo_evt = rx_push || rx_read;
  assign rx_rdy   = rx_ready_fn(int'(rx_level), rx_trig, FIFO_DEPTH);
  assign tx_rdy   = tx_ready_fn(int'(tx_level), tx_trig, FIFO_DEPTH);

  assign st_set = {cos_evt, addr_evt, flow_evt, brk_evt};
  assign st_clr = {inport_rd,
                   cmd_valid && (cmd_code == CMD_CLR_ADDR),
                   flow_rd,
                   cmd_valid && (cmd_code == CMD_CLR_BRK)};

  uart_irq_sticky #(.NUM(NSTICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(st_clr), .flag_o(st_q));

  uart_irq_rx_wdog #(.WDOG_BITS(WDOG_BITS)) u_wdog (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .fifo_evt(fifo_evt), .timeout(wdog_to));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata & ~(8'(1) << BIT_RSV);
  end

  always_comb begin
    isr           = '0;
    isr[BIT_TXR]  = tx_rdy;
    isr[BIT_RXR]  = rx_rdy;
    isr[BIT_BRK]  = st_q[0];
    isr[BIT_FLOW] = st_q[1];
    isr[BIT_ADDR] = st_q[2];
    isr[BIT_COS]  = st_q[3];
    isr[BIT_WDOG] = wdog_to;
  end

  assign pending = isr & mask_q;
  assign irq_n   = ~|pending;
  assign rd_data = masked_rd ? pending : isr;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[BIT_RSV]); // R1
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (mask_q != 8'h00)); // R2
  AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    masked_rd |-> ((rd_data & ~mask_q) == 8'h00)); // R3
  AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !isr[BIT_RXR]); // R5
  AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LW'(FIFO_DEPTH)) |-> !isr[BIT_TXR]); // R6
  AST_BRK_CMD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_CLR_BRK && !brk_evt) |=> !rd_data[BIT_BRK] || masked_rd); // R7
endmodule

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;
  logic clk = 0, rst_n = 0;
  logic baud_tick = 0, rx_push = 0, rx_read = 0;
  logic [4:0] rx_level = 0, tx_level = 0;
  logic [1:0] rx_trig = 0, tx_trig = 0;
  logic brk_evt = 0, addr_evt = 0, flow_evt = 0, cos_evt = 0;
  logic cmd_valid = 0; logic [4:0] cmd_code = 0;
  logic flow_rd = 0, inport_rd = 0, mask_wr = 0; logic [7:0] mask_wdata = 0;
  logic masked_rd = 0;
  logic [7:0] rd_data; logic irq_n;

  int checks = 0, errors = 0, cycles = 0;

  // reference state
  bit m_brk, m_flow, m_addr, m_cos, m_wflag;
  int m_wcnt;
  bit [7:0] m_mask;

  always #4 clk = ~clk;

  uart_irq_status uut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_brk = 0; m_flow = 0; m_addr = 0; m_cos = 0; m_wflag = 0; m_wcnt = 0; m_mask = 0;
    end else begin
      if (brk_evt) m_brk = 1; else if (cmd_valid && cmd_code == 5'd5) m_brk = 0;
      if (addr_evt) m_addr = 1; else if (cmd_valid && cmd_code == 5'd27) m_addr = 0;
      if (flow_evt) m_flow = 1; else if (flow_rd) m_flow = 0;
      if (cos_evt) m_cos = 1; else if (inport_rd) m_cos = 0;
      if (rx_push || rx_read) begin m_wcnt = 0; m_wflag = 0; end
      else if (baud_tick) begin
        m_wcnt++;
        if (m_wcnt == 65) m_wflag = 1;
        if (m_wcnt > 65) m_wcnt = 65;
      end
      if (mask_wr) begin m_mask = mask_wdata; m_mask[3] = 0; end
    end
  end

  function automatic bit [7:0] exp_status();
    bit [7:0] s = 0;
    int rl = rx_level, tl = tx_level;
    s[7] = m_cos; s[6] = m_wflag; s[5] = m_addr; s[4] = m_flow; s[2] = m_brk;
    case (rx_trig) 0: s[1] = rl > 0; 1: s[1] = rl > 7; 2: s[1] = rl > 11; default: s[1] = rl == 16; endcase
    case (tx_trig) 0: s[0] = tl == 0; 1: s[0] = tl <= 3; 2: s[0] = tl <= 7; default: s[0] = tl != 16; endcase
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare();
    bit [7:0] s = exp_status();
    bit [7:0] e = masked_rd ? (s & m_mask) : s;
    string lbl [8] = '{"R6", "R5", "R7", "R1", "R8", "R8", "R4", "R8"};
    for (int b = 0; b < 8; b++)
      chk(rd_data[b] === e[b], masked_rd ? {lbl[b], "/R3"} : lbl[b], rd_data, e);
    chk(irq_n === ((s & m_mask) == 0), "R2", irq_n, (s & m_mask) == 0);
  endtask

  task automatic clear_pulses();
    baud_tick = 0; rx_push = 0; rx_read = 0; brk_evt = 0; addr_evt = 0;
    flow_evt = 0; cos_evt = 0; cmd_valid = 0; flow_rd = 0; inport_rd = 0; mask_wr = 0;
  endtask

  task automatic cyc();
    #1 compare();
    @(negedge clk);
    clear_pulses();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10: reset state
    chk(irq_n === 1'b1, "R10", irq_n, 1);
    chk(rd_data === 8'h01, "R10", rd_data, 8'h01);
    @(negedge clk);

    // R4: watchdog boundary at tick 64 and 65
    for (int i = 0; i < 64; i++) begin baud_tick = 1; cyc(); end
    #1 chk(rd_data[6] === 1'b0, "R4", rd_data[6], 0);
    @(negedge clk);
    baud_tick = 1; cyc();
    #1 chk(rd_data[6] === 1'b1, "R4", rd_data[6], 1);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin baud_tick = 1; cyc(); end
    rx_push = 1; baud_tick = 1; cyc();
    #1 chk(rd_data[6] === 1'b0, "R4", rd_data[6], 0);
    @(negedge clk);

    // R5 / R6: every trigger code across every fill level
    for (int t = 0; t < 4; t++)
      for (int l = 0; l <= 16; l++) begin
        rx_trig = 2'(t); tx_trig = 2'(t); rx_level = 5'(l); tx_level = 5'(l); cyc();
      end

    // R7: set and clear in the same cycle keeps the flag
    brk_evt = 1; cyc();
    brk_evt = 1; cmd_valid = 1; cmd_code = 5'b00101; cyc();
    #1 chk(rd_data[2] === 1'b1, "R7", rd_data[2], 1);
    @(negedge clk);
    // R9: non-matching codes leave flags alone
    addr_evt = 1; flow_evt = 1; cos_evt = 1; cyc();
    for (int c = 0; c < 32; c++) begin
      if (c != 5 && c != 27) begin cmd_valid = 1; cmd_code = 5'(c); cyc(); end
    end
    #1 chk((rd_data & 8'hB4) === 8'hB4, "R9", rd_data, 8'hB4);
    @(negedge clk);
    cmd_valid = 1; cmd_code = 5'b11011; cyc();
    cmd_valid = 1; cmd_code = 5'b00101; flow_rd = 1; inport_rd = 1; cyc();
    #1 chk((rd_data & 8'hB4) === 8'h00, "R8", rd_data, 0);
    @(negedge clk);

    // R2 / R3: masked reads and request output
    mask_wr = 1; mask_wdata = 8'hFF; cyc();
    masked_rd = 1; cyc();
    masked_rd = 0; cyc();

    // randomized segments with varying event density
    for (int seg = 0; seg < 40; seg++) begin
      int dens = (seg % 4 == 0) ? 400 : 12;
      for (int i = 0; i < 60; i++) begin
        baud_tick = ($urandom % 2) == 0;
        rx_push = ($urandom % dens) == 0;
        rx_read = ($urandom % dens) == 0;
        brk_evt = ($urandom % 9) == 0; addr_evt = ($urandom % 9) == 0;
        flow_evt = ($urandom % 9) == 0; cos_evt = ($urandom % 9) == 0;
        cmd_valid = ($urandom % 5) == 0;
        cmd_code = ($urandom % 2) ? 5'($urandom) : (($urandom % 2) ? 5'd5 : 5'd27);
        flow_rd = ($urandom % 7) == 0; inport_rd = ($urandom % 7) == 0;
        mask_wr = ($urandom % 15) == 0; mask_wdata = 8'($urandom);
        if (($urandom % 6) == 0) begin
          rx_level = 5'($urandom % 17); tx_level = 5'($urandom % 17);
          rx_trig = 2'($urandom); tx_trig = 2'($urandom);
        end
        if (($urandom % 10) == 0) masked_rd = ~masked_rd;
        cyc();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule